// File: doc/BRIEF.md
# Peripheral Register Bit-Field Access Unit

This unit carries out the two peripheral-register instructions of a small coprocessor. Each instruction names a target register in one of four 32-bit register banks and a bit range inside it. The range is given by a low index and a high index, both inclusive. A write instruction replaces only that range with an 8-bit literal and keeps every other bit of the register. It does this with a read-modify-write over the bank bus. A read instruction fetches the register, right-aligns the selected range and hands it back as the new value of the coprocessor's register R0.

The coprocessor presents one 32-bit instruction word together with a one-cycle `start`. The unit runs its bus sequence and then raises `done` for one clock. On a read, `r0_valid` rises in the same cycle, and the result is on `r0_value`. The banks sit behind a single synchronous bus. Read data is returned in the cycle after a read request.

Top module: `bitfield_access_unit`

## Requirements
- R1: Instruction bits, counted from bit 0: [7:0] word address, [9:8] bank select, [17:10] data literal, [22:18] low index, [27:23] high index, [31:28] opcode. Opcode 1 is a write and opcode 2 is a read. A `start` with any other opcode is ignored: there is no bus cycle and no `done`.
- R2: During the bus cycles of an instruction, `bus_bank` carries the bank select (0 to 3) and `bus_addr` carries the word address. Both stay unchanged between the read cycle and the write cycle.
- R3: After a write, bits [high:low] of the target register equal the low (high-low+1) bits of the data literal, zero-extended. Data bits above the field width are dropped. All other bits of the register, and all other registers, are unchanged.
- R4: A write with low equal to high sets or clears exactly that one bit, following data bit 0.
- R5: A read returns bits [high:low] of the target register, shifted down to bit 0 and zero-extended to 16 bits. Only the low 16 bits are kept when the field is wider than 16. `r0_valid` is high only together with `done`. `r0_value` holds its value until the next read.
- R6: A write makes exactly one bus read cycle and then exactly one bus write cycle. The write cycle comes two clocks after the read request. `done` is high in the clock after the write cycle, four clocks after the clock in which `start` was sampled.
- R7: A read makes exactly one bus read cycle and no bus write cycle. `done` comes three clocks after `start` was sampled.
- R8: An instruction of opcode 1 or 2 with high less than low is a no-op. It makes no bus cycle, leaves the banks and `r0_value` unchanged, does not raise `r0_valid`, and raises `done` one clock after `start` was sampled.
- R9: `done` is a single-clock pulse. A `start` while an instruction is in progress, including its `done` cycle, is ignored.
- R10: After a synchronous active-low reset, `done`, `r0_valid`, `bus_rd_en` and `bus_wr_en` are low and `r0_value` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Instruction present for one clock |
| instr | input | 32 | Instruction word |
| done | output | 1 | One-clock completion pulse |
| r0_valid | output | 1 | Read result present on r0_value |
| r0_value | output | 16 | Extracted field for R0 |
| bus_rd_en | output | 1 | Bank read request; data returns next clock |
| bus_wr_en | output | 1 | Bank write strobe |
| bus_bank | output | 2 | Bank select |
| bus_addr | output | 8 | Word address inside the bank |
| bus_wdata | output | 32 | Merged register value to write |
| bus_rdata | input | 32 | Registered read data from the selected bank |

## Verification
Two things can land in the same cycle here. One is a new `start` arriving while a write is still in flight. The other is the `done` pulse meeting the bus write of the instruction before it. The bench provokes the first by raising a second `start` in the write cycle and again in the `done` cycle. It then judges that only one `done` appears, that the bank and R0 show the effect of the first instruction alone, and that the bus counters show no extra cycle. Random writes and reads over all banks and bit ranges are each compared against a bench-side merge and extract, and their latencies are counted.

// File: rtl/bfa_pkg.sv
// Package: shared widths, instruction layout and sequencer states for the
// bit-field access unit. Assumes a 32-bit instruction word.
package bfa_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int BANK_W = 2;
    localparam int LIT_W  = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OPC_W  = 4;
    localparam int R0_W   = 16;
    localparam int INSTR_W = OPC_W + 2 * IDX_W + LIT_W + BANK_W + ADDR_W;

    localparam logic [OPC_W-1:0] OPC_FIELD_WRITE = 4'd1;
    localparam logic [OPC_W-1:0] OPC_FIELD_READ  = 4'd2;

    // Packed most significant field first, so addr lands at bit 0.
    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [IDX_W-1:0]  hi;
        logic [IDX_W-1:0]  lo;
        logic [LIT_W-1:0]  literal;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } bfa_instr_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RDREQ,
        SEQ_RDWAIT,
        SEQ_WRITE,
        SEQ_FIN
    } bfa_state_e;
endpackage

// File: rtl/bfa_decode.sv
// Module: splits an instruction word into its fields and classifies it.
// Assumes: purely combinational; the caller decides when the word is valid.
module bfa_decode
    import bfa_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bfa_instr_t         fields,
    output logic               is_write,
    output logic               is_read,
    output logic               range_ok
);
    // Field split and opcode / range classification.
    always_comb begin
        fields   = bfa_instr_t'(instr);
        is_write = (fields.opcode == OPC_FIELD_WRITE);
        is_read  = (fields.opcode == OPC_FIELD_READ);
        range_ok = (fields.hi >= fields.lo);
    end
endmodule

// File: rtl/bfa_mask.sv
// Module: builds the bit mask covering [hi:lo] inclusive.
// Assumes: hi < lo yields an all-zero mask; the caller treats that as a no-op.
module bfa_mask
    import bfa_pkg::*;
(
    input  logic [IDX_W-1:0]  lo,
    input  logic [IDX_W-1:0]  hi,
    output logic [DATA_W-1:0] mask
);
    // One comparator pair per register bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask[i] = (IDX_W'(i) >= lo) && (IDX_W'(i) <= hi);
    end
endmodule

// File: rtl/bfa_field.sv
// Module: merges a literal into a register value and extracts a field from it.
// Assumes: mask already covers exactly [hi:lo]; literal bits shifted past the
// mask or past the top bit are discarded.
module bfa_field
    import bfa_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] mask,
    input  logic [IDX_W-1:0]  lo,
    input  logic [LIT_W-1:0]  literal,
    output logic [DATA_W-1:0] merged,
    output logic [R0_W-1:0]   extracted
);
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] aligned;

    // Read-modify-write merge and right-aligned extraction.
    always_comb begin
        placed    = (DATA_W'(literal) << lo) & mask;
        merged    = (cur & ~mask) | placed;
        aligned   = (cur & mask) >> lo;
        extracted = aligned[R0_W-1:0];
    end
endmodule

// File: rtl/bitfield_access_unit.sv
// Module: top of the peripheral register bit-field access unit.
// Accepts one instruction when idle, runs read (and for writes, write) bus
// cycles, then pulses done. Assumes bus_rdata is valid the clock after
// bus_rd_en and that the banks accept a write in the bus_wr_en clock.
module bitfield_access_unit
    import bfa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 done,
    output logic                 r0_valid,
    output logic [R0_W-1:0]      r0_value,
    output logic                 bus_rd_en,
    output logic                 bus_wr_en,
    output logic [BANK_W-1:0]    bus_bank,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W-1:0]    bus_rdata
);
    bfa_state_e          state;
    logic [INSTR_W-1:0]  instr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [R0_W-1:0]     r0_q;

    bfa_instr_t          in_f;
    logic                in_wr, in_rd, in_ok;
    bfa_instr_t          q_f;
    logic                q_wr, q_rd, q_ok;
    logic [DATA_W-1:0]   mask;
    logic [DATA_W-1:0]   merged;
    logic [R0_W-1:0]     extracted;

    bfa_decode u_dec_in (
        .instr(instr), .fields(in_f), .is_write(in_wr), .is_read(in_rd), .range_ok(in_ok)
    );

    bfa_decode u_dec_q (
        .instr(instr_q), .fields(q_f), .is_write(q_wr), .is_read(q_rd), .range_ok(q_ok)
    );

    bfa_mask u_mask (
        .lo(q_f.lo), .hi(q_f.hi), .mask(mask)
    );

    bfa_field u_field (
        .cur(bus_rdata), .mask(mask), .lo(q_f.lo), .literal(q_f.literal),
        .merged(merged), .extracted(extracted)
    );

    // Sequencer: accept, read request, capture, optional write, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            instr_q <= '0;
            wdata_q <= '0;
            r0_q    <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start && (in_wr || in_rd)) begin
                        instr_q <= instr;
                        state   <= in_ok ? SEQ_RDREQ : SEQ_FIN;
                    end
                end
                SEQ_RDREQ: state <= SEQ_RDWAIT;
                SEQ_RDWAIT: begin
                    if (q_wr) begin
                        wdata_q <= merged;
                        state   <= SEQ_WRITE;
                    end else begin
                        r0_q  <= extracted;
                        state <= SEQ_FIN;
                    end
                end
                SEQ_WRITE: state <= SEQ_FIN;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Output decode from the sequencer state and the held instruction.
    always_comb begin
        bus_rd_en = (state == SEQ_RDREQ);
        bus_wr_en = (state == SEQ_WRITE);
        done      = (state == SEQ_FIN);
        r0_valid  = done && q_rd && q_ok;
        bus_bank  = q_f.bank;
        bus_addr  = q_f.addr;
        bus_wdata = wdata_q;
        r0_value  = r0_q;
    end
endmodule

// File: rtl/bfa_checker.sv
// Module: temporal checks on the ports of bitfield_access_unit, bound below.
// Assumes synchronous active-low reset; every property is disabled in reset.
module bfa_checker
    import bfa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              r0_valid,
    input logic              bus_rd_en,
    input logic              bus_wr_en,
    input logic [BANK_W-1:0] bus_bank,
    input logic [ADDR_W-1:0] bus_addr
);
    p_bus_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_en && bus_wr_en));

    p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> $past(bus_rd_en, 2));

    p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |=> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_r0_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r0_valid |-> done);

    p_target_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> ($stable(bus_bank) && $stable(bus_addr)));
endmodule

bind bitfield_access_unit bfa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .r0_valid(r0_valid),
    .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en),
    .bus_bank(bus_bank), .bus_addr(bus_addr)
);

// File: tb/bitfield_access_unit_test.sv
module bitfield_access_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        done, r0_valid, bus_rd_en, bus_wr_en;
    logic [15:0] r0_value;
    logic [1:0]  bus_bank;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic [31:0] mem [4][256];

    always #2.5 clk = ~clk;

    bitfield_access_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .done(done), .r0_valid(r0_valid), .r0_value(r0_value),
        .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en), .bus_bank(bus_bank),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Bank model: registered read, write on strobe; activity counters.
    always @(posedge clk) begin
        if (bus_rd_en) begin bus_rdata <= mem[bus_bank][bus_addr]; rd_cnt <= rd_cnt + 1; end
        if (bus_wr_en) begin mem[bus_bank][bus_addr] <= bus_wdata; wr_cnt <= wr_cnt + 1; end
        if (done) done_cnt <= done_cnt + 1;
    end

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [1:0] bk,
            input logic [7:0] ad, input logic [7:0] dt, input logic [4:0] lo, input logic [4:0] hi);
        return {op, hi, lo, dt, bk, ad};
    endfunction

    function automatic logic [31:0] fmask(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] exp_write(input logic [31:0] old, input int lo, input int hi,
            input logic [7:0] dt);
        logic [31:0] m = fmask(lo, hi);
        return (old & ~m) | ((32'(dt) << lo) & m);
    endfunction

    function automatic logic [15:0] exp_read(input logic [31:0] old, input int lo, input int hi);
        logic [31:0] v = (old & fmask(lo, hi)) >> lo;
        return v[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Issue one instruction, return latency in clocks until done (0 = none seen).
    task automatic run(input logic [31:0] ins, input int limit, output int lat, output bit rv);
        lat = 0; rv = 0;
        @(negedge clk); start = 1'b1; instr = ins;
        @(negedge clk); start = 1'b0;
        for (int c = 1; c <= limit; c++) begin
            if (done) begin lat = c; rv = r0_valid; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] bk, input logic [7:0] ad, input logic [7:0] dt,
            input int lo, input int hi, input string req);
        logic [31:0] old = mem[bk][ad];
        logic [31:0] nb  = mem[bk][ad + 8'd1];
        logic [31:0] ob  = mem[bk ^ 2'd1][ad];
        int r0 = rd_cnt, w0 = wr_cnt, lat;
        bit rv;
        run(mk(4'd1, bk, ad, dt, 5'(lo), 5'(hi)), 8, lat, rv);
        check(mem[bk][ad] == exp_write(old, lo, hi, dt), req, mem[bk][ad], exp_write(old, lo, hi, dt));
        check(mem[bk][ad + 8'd1] == nb && mem[bk ^ 2'd1][ad] == ob, "R3 neighbours", mem[bk ^ 2'd1][ad], ob);
        check(lat == 4 && !rv, "R6 write latency", 32'(lat), 32'd4);
        check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, "R6 bus cycles", 32'(wr_cnt - w0), 32'd1);
    endtask

    task automatic do_read(input logic [1:0] bk, input logic [7:0] ad, input int lo, input int hi);
        logic [15:0] e = exp_read(mem[bk][ad], lo, hi);
        int w0 = wr_cnt, lat;
        bit rv;
        run(mk(4'd2, bk, ad, 8'hA5, 5'(lo), 5'(hi)), 8, lat, rv);
        check(r0_value == e, "R5 read value", 32'(r0_value), 32'(e));
        check(lat == 3 && rv, "R7 read latency/valid", 32'(lat), 32'd3);
        check(wr_cnt == w0, "R7 no bus write", 32'(wr_cnt - w0), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat, r0s, w0s, d0;
        bit rv;
        logic [31:0] keep;
        logic [15:0] r0keep;
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 256; a++) mem[b][a] = $urandom();
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!done && !r0_valid && !bus_rd_en && !bus_wr_en && r0_value == 16'd0,
              "R10 reset", {r0_value, 12'd0, done, r0_valid, bus_rd_en, bus_wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: full word, top bits, R4 single-bit set and clear
        do_write(2'd0, 8'd3, 8'hFF, 0, 31, "R3 full-width write");
        do_write(2'd3, 8'd200, 8'h5A, 28, 31, "R3 top field, literal truncated");
        mem[2][9] = 32'h0000_0000;
        do_write(2'd2, 8'd9, 8'h01, 17, 17, "R4 set single bit");
        check(mem[2][9] == 32'h0002_0000, "R4 set bit 17", mem[2][9], 32'h0002_0000);
        mem[1][9] = 32'hFFFF_FFFF;
        do_write(2'd1, 8'd9, 8'hFE, 5, 5, "R4 clear single bit");
        check(mem[1][9] == 32'hFFFF_FFDF, "R4 clear bit 5", mem[1][9], 32'hFFFF_FFDF);
        // R5 wide field truncation and R2 bank routing
        mem[1][44] = 32'hDEAD_BEEF;
        do_read(2'd1, 8'd44, 4, 27);
        check(r0_value == 16'hDBEE, "R5 wide field low 16 bits", 32'(r0_value), 32'hDBEE);
        mem[3][44] = 32'h0000_0C00;
        do_read(2'd3, 8'd44, 10, 11);
        check(r0_value == 16'h0003, "R2 bank 3 read", 32'(r0_value), 32'h3);

        // R8 high < low: no-op with done after one clock
        keep = mem[0][5]; r0keep = r0_value; r0s = rd_cnt; w0s = wr_cnt;
        run(mk(4'd1, 2'd0, 8'd5, 8'hFF, 5'd9, 5'd3), 8, lat, rv);
        check(lat == 1 && !rv, "R8 write no-op latency", 32'(lat), 32'd1);
        check(mem[0][5] == keep && rd_cnt == r0s && wr_cnt == w0s, "R8 no bus effect", mem[0][5], keep);
        run(mk(4'd2, 2'd0, 8'd5, 8'h00, 5'd20, 5'd2), 8, lat, rv);
        check(lat == 1 && !rv && r0_value == r0keep, "R8 read no-op", 32'(r0_value), 32'(r0keep));

        // R1 other opcodes ignored
        r0s = rd_cnt; w0s = wr_cnt; d0 = done_cnt;
        run(mk(4'd0, 2'd0, 8'd5, 8'hFF, 5'd0, 5'd7), 6, lat, rv);
        run(mk(4'd3, 2'd0, 8'd5, 8'hFF, 5'd0, 5'd7), 6, lat, rv);
        run(mk(4'd15, 2'd1, 8'd5, 8'hFF, 5'd0, 5'd7), 6, lat, rv);
        check(done_cnt == d0 && rd_cnt == r0s && wr_cnt == w0s, "R1 foreign opcode ignored",
              32'(done_cnt - d0), 32'd0);

        // R9 start while busy: second start in write cycle and in done cycle
        keep = exp_write(mem[2][77], 8, 15, 8'h3C);
        r0keep = r0_value; d0 = done_cnt; r0s = rd_cnt; w0s = wr_cnt;
        @(negedge clk); start = 1'b1; instr = mk(4'd1, 2'd2, 8'd77, 8'h3C, 5'd8, 5'd15);
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk); start = 1'b1; instr = mk(4'd2, 2'd0, 8'd1, 8'h00, 5'd0, 5'd15);
        @(negedge clk); instr = mk(4'd1, 2'd0, 8'd1, 8'h00, 5'd0, 5'd7);
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        check(done_cnt - d0 == 1, "R9 single done for overlapped starts", 32'(done_cnt - d0), 32'd1);
        check(mem[2][77] == keep && r0_value == r0keep, "R9 busy start has no effect", mem[2][77], keep);
        check(rd_cnt - r0s == 1 && wr_cnt - w0s == 1, "R9 no extra bus cycles", 32'(rd_cnt - r0s), 32'd1);

        // Random mix of writes and reads over banks and ranges (R2 R3 R5 R6 R7)
        for (int n = 0; n < 300; n++) begin
            logic [1:0] bk = 2'($urandom_range(0, 3));
            logic [7:0] ad = 8'($urandom_range(0, 254));
            int lo = $urandom_range(0, 31);
            int hi = $urandom_range(lo, 31);
            if ($urandom_range(0, 1) == 0)
                do_write(bk, ad, 8'($urandom()), lo, hi, "R3 random write");
            else
                do_read(bk, ad, lo, hi);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule